// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block supervises a processor by watching one watchdog line that the processor is expected to toggle. Every transition on that line, whether low-to-high or high-to-low, restarts an internal tick counter. If the line holds a constant level, either high or low, for a full timeout period, the block emits a single-cycle expiry strobe. A reset controller can use this strobe to start a reset.

The watchdog line is asynchronous to the block clock. It passes through a synchronizer chain, and a transition is detected by comparing the synchronized level with its value one cycle earlier. The reset controller supplies a reset-active flag. While that flag is high, the counter, the synchronizer and the edge history are all held clear, so no expiry can occur during reset. The timeout is a parameter in clock ticks. Its default models about 1.6 s at 100 MHz, and any value in roughly 1.12 s to 2.24 s of ticks is acceptable. No input can disable the watchdog.

Top module: `wdog_edge_timer`

## Requirements
- R1: With the watchdog line held constant low from the end of reset, `expire_o` is high in exactly the cycle that follows the TIMEOUT_TICKS-th rising clock edge after `rst_active_i` is sampled low.
- R2: `expire_o` is high for exactly one cycle. The counter then restarts from zero, so a still-constant line produces the next strobe TIMEOUT_TICKS edges later.
- R3: A low-to-high change of `wdi_async_i` made between clock edges clears the counter. If no further change occurs, the next strobe follows the (TIMEOUT_TICKS+SYNC_STAGES+1)-th rising edge after the change.
- R4: A high-to-low change of `wdi_async_i` clears the counter with the same timing as R3.
- R5: While changes arrive no more than TIMEOUT_TICKS edges apart, `expire_o` stays low.
- R6: While `rst_active_i` is high, `expire_o` is low and the line is ignored. After release, timing restarts from zero as in R1, however long reset lasted and wherever the count stood.
- R7: A pulse on `wdi_async_i` one clock period wide is seen as two transitions. Timing restarts from the second transition.
- R8: A transition whose clear lands on the same edge at which the count would expire wins. No strobe is issued, and the next strobe comes TIMEOUT_TICKS edges after that clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| wdi_async_i | input | 1 | Asynchronous watchdog line from the processor |
| rst_active_i | input | 1 | High while the reset controller holds reset; clears all state |
| expire_o | output | 1 | Single-cycle strobe on watchdog timeout |

## Verification
The bench builds the block with TIMEOUT_TICKS = 20 and SYNC_STAGES = 2. This keeps every timeout down to a few dozen cycles, so each spacing between two transitions can be swept. The sweep covers spacings from one cycle up to four cycles past the timeout, starting from both line polarities. It reaches the one-cycle pulse, the exact tie between a clear and an expiry, and the case where a strobe fires before the late transition. Separate runs hold reset over line activity and cut a count short partway through.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // Bits needed to hold values 0 .. ticks-1 (at least one bit).
   function automatic int unsigned cnt_bits(input int unsigned ticks);
      int unsigned b;
      b = 1;
      while ((64'd1 << b) < 64'(ticks)) b++;
      return b;
   endfunction
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic clr_i,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wdt_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr_i) chain_q <= '0;
      else       chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdt_edge.sv
module wdt_edge (
   input  logic clk,
   input  logic clr_i,
   input  logic lvl_i,
   output logic kick_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (clr_i) prev_q <= 1'b0;
      else       prev_q <= lvl_i;
   end

   // Either polarity of transition restarts the timer.
   assign kick_o = lvl_i ^ prev_q;

   // R4 / R3: a detected transition is always followed by the level settling into history
   assert_kick_settles_R4: assert property (@(posedge clk) disable iff (clr_i)
      kick_o |=> (prev_q == $past(lvl_i)));
endmodule

// File: rtl/wdt_count.sv
module wdt_count
   import wdt_pkg::*;
#(
   parameter int unsigned TICKS = 160_000_000
) (
   input  logic clk,
   input  logic clr_i,
   input  logic kick_i,
   output logic expire_o
);
   localparam int unsigned W = cnt_bits(TICKS);
   localparam logic [W-1:0] LIMIT = W'(TICKS - 1);

   logic [W-1:0] cnt_q;
   logic         exp_q;

   generate
      if (TICKS < 4) begin : g_bad_ticks
         $error("wdt_count: TICKS must be at least 4");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (clr_i) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else begin
         exp_q <= 1'b0;
         if (kick_i) begin
            cnt_q <= '0;               // clear wins over expiry (R8)
         end else if (cnt_q == LIMIT) begin
            cnt_q <= '0;               // restart after firing (R2)
            exp_q <= 1'b1;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign expire_o = exp_q;

   assert_single_pulse_R2: assert property (@(posedge clk) disable iff (clr_i)
      expire_o |=> !expire_o);
   assert_kick_blocks_R5: assert property (@(posedge clk) disable iff (clr_i)
      kick_i |=> !expire_o);
   assert_count_bound_R1: assert property (@(posedge clk) disable iff (clr_i)
      cnt_q <= LIMIT);
   assert_restart_R2: assert property (@(posedge clk) disable iff (clr_i)
      expire_o |-> (cnt_q == '0));
endmodule

// File: rtl/wdog_edge_timer.sv
module wdog_edge_timer #(
   parameter int unsigned TIMEOUT_TICKS = 160_000_000,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic wdi_async_i,
   input  logic rst_active_i,
   output logic expire_o
);
   logic wdi_sync;
   logic kick;

   wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .clr_i (rst_active_i),
      .d_i   (wdi_async_i),
      .q_o   (wdi_sync)
   );

   wdt_edge u_edge (
      .clk    (clk),
      .clr_i  (rst_active_i),
      .lvl_i  (wdi_sync),
      .kick_o (kick)
   );

   wdt_count #(.TICKS(TIMEOUT_TICKS)) u_count (
      .clk      (clk),
      .clr_i    (rst_active_i),
      .kick_i   (kick),
      .expire_o (expire_o)
   );

   // R6: the cycle after reset is seen, no strobe can be present
   assert_quiet_after_hold_R6: assert property (@(posedge clk) disable iff (rst_active_i)
      $past(rst_active_i) |-> !expire_o);
endmodule

// File: tb/wdog_edge_timer_tb.sv
`timescale 1ns/1ps
module wdog_edge_timer_tb;
   localparam int T = 20;
   localparam int S = 2;

   logic clk = 1'b0;
   logic wdi = 1'b0;
   logic hold = 1'b1;
   logic expire;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   wdog_edge_timer #(.TIMEOUT_TICKS(T), .SYNC_STAGES(S)) u_dut (
      .clk          (clk),
      .wdi_async_i  (wdi),
      .rst_active_i (hold),
      .expire_o     (expire)
   );

   task automatic check(input string req, input logic act, input logic exp, input int cyc);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d: expire actual %b expected %b", req, cyc, act, exp);
      end
   endtask

   // Change line after reset settles; change back after d more edges.
   task automatic run_gap(input logic lvl, input int d);
      string req;
      req = lvl ? "R4" : "R3";
      @(negedge clk); hold = 1'b1; wdi = lvl;
      repeat (4) @(negedge clk);
      hold = 1'b0;
      repeat (4) @(negedge clk);
      wdi = ~lvl;
      for (int c = 1; c <= d + T + S + 4; c++) begin
         logic e;
         @(negedge clk);
         // first transition expires at T+S+1; second at d+T+S+1; tie goes to the clear (R8)
         e = ((c == T + S + 1) && (d > T)) || (c == d + T + S + 1);
         check((d == 1) ? "R7" : (d == T) ? "R8" : (d <= T) ? "R5" : req, expire, e, c);
         if (c == d) wdi = lvl;
      end
   endtask

   initial begin
      // R6: quiet while held, line activity ignored
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         wdi = i[1];
         check("R6", expire, 1'b0, i);
      end
      wdi = 1'b0;
      @(negedge clk);
      hold = 1'b0;
      // R1 then R2: strobes after edge T and 2T, each one cycle wide
      for (int c = 1; c <= 2 * T + 2; c++) begin
         @(negedge clk);
         check((c <= T) ? "R1" : "R2", expire, (c == T) || (c == 2 * T), c);
      end
      // R6: reset partway through a count restarts timing
      @(negedge clk); hold = 1'b1;
      @(negedge clk); hold = 1'b0;
      for (int c = 1; c <= T - 5; c++) @(negedge clk);
      hold = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check("R6", expire, 1'b0, 0);
      end
      hold = 1'b0;
      for (int c = 1; c <= T + 1; c++) begin
         @(negedge clk);
         check("R6", expire, c == T, c);
      end
      // Sweep of transition spacing, both polarities (R3 R4 R5 R7 R8)
      for (int p = 0; p < 2; p++)
         for (int d = 1; d <= T + 4; d++)
            run_gap(p[0], d);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule